// File: doc/BRIEF.md
# Synchronous Trace Port Driver

This block sits between a trace formatter and the trace pins. It receives bytes from the formatter over a valid/ready handshake and sends each one out on a synchronous trace port that is 1, 2 or 4 data pins wide. With each byte it also drives an enable that lets the trace clock run. The block holds two configuration fields: a protocol selector and a port-size code. A separate trace I/O enable input decides when the trace clock may start.

The trace clock is held off after reset. It is handed over to the system clock a fixed number of cycles after the I/O enable goes high; two cycles by default. Data moves only when the clock is running and the protocol field selects synchronous mode. Each byte is cut into slices that match the latched port width and is sent least-significant slice first. A new port size is latched only when a new byte starts.

Top module: `trace_port_sync`

## Requirements
- R1: Reset makes the protocol readback `cfg_proto` equal to 2'b01 and the size readback `cfg_size` equal to 4'h1. A pulse on `cfg_we` loads both fields from their inputs on the next rising edge.
- R2: `tclk_run` is 0 from reset. It follows `trace_io_en` with a delay of exactly two rising edges, both when the enable goes high and when it goes low.
- R3: A size code of 4'h1 selects 1 pin, 4'h2 selects 2 pins and 4'h8 selects 4 pins. Every other code selects 1 pin.
- R4: A byte accepted on a rising edge is shown on `trace_d`, starting after that edge. Its lowest slice comes first and the next higher slice follows each cycle, for 8, 4 or 2 cycles at 1, 2 or 4 pins. Slice k at width w is `(byte >> (k*w))` masked to w bits.
- R5: Data pins beyond the selected width read 0. With 1 pin these are `trace_d[3:1]`, with 2 pins `trace_d[3:2]`. With no byte in progress all four pins read 0.
- R6: While `cfg_proto` is not 2'b00, `in_ready` is 0 and `trace_d` is 0. A byte offered during that time stays unconsumed and is taken once the protocol becomes 2'b00.
- R7: A size change written while a byte is being sent does not alter the width of that byte. The new width applies from the next byte accepted.
- R8: `in_ready` is 1 only when the clock runs, the protocol is 2'b00 and the current slice is the last one or no byte is active. A byte offered during a last slice follows with no gap cycle.
- R9: While `tclk_run` is 0, no byte is consumed and `trace_d` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trace_io_en | input | 1 | Trace I/O enable; starts the clock hand-over |
| cfg_we | input | 1 | Write strobe for both configuration fields |
| cfg_proto_in | input | 2 | New protocol value (00 synchronous, 01/10 serial) |
| cfg_size_in | input | 4 | New port-size code |
| cfg_proto | output | 2 | Current protocol field |
| cfg_size | output | 4 | Current port-size code |
| in_valid | input | 1 | Formatter byte valid |
| in_data | input | 8 | Formatter byte |
| in_ready | output | 1 | Block takes the byte on this edge |
| tclk_run | output | 1 | Trace clock enable (clock runs when 1) |
| trace_d | output | 4 | Trace data pins |

## Verification
Configuration writes show on the readbacks one edge after the strobe. The clock enable follows the I/O enable exactly two edges later, so the bench checks it after one edge, where it must still hold its old value, and again after the second edge. A byte taken on an edge puts its first slice on the pins right after that edge and a new slice after every following edge. `in_ready` rises while the last slice is on the pins. The bench drives inputs and samples outputs on falling edges, so each check sees exactly one rising edge since the previous one, and it counts those edges against the number of registers in the path.

// File: rtl/trace_port_pkg.sv
// Shared types and helpers for the synchronous trace port.
// Assumes byte-wide input and at most four data pins.
package trace_port_pkg;
    localparam int BYTE_W = 8;
    localparam int PINS_MAX = 4;

    typedef enum logic [1:0] {TW_1 = 2'd0, TW_2 = 2'd1, TW_4 = 2'd2} tw_e;

    // Map a port-size code to a width; unknown codes fall back to one pin.
    function automatic tw_e size_decode(input logic [3:0] code);
        case (code)
            4'h2:    return TW_2;
            4'h8:    return TW_4;
            default: return TW_1;
        endcase
    endfunction

    // Pins used at a width, as a shift amount.
    function automatic logic [2:0] width_bits(input tw_e w);
        case (w)
            TW_2:    return 3'd2;
            TW_4:    return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    // Index of the last slice of a byte at a width.
    function automatic logic [2:0] last_slice(input tw_e w);
        case (w)
            TW_2:    return 3'd3;
            TW_4:    return 3'd1;
            default: return 3'd7;
        endcase
    endfunction

    // Lowest slice of a byte, with unused pins zeroed.
    function automatic logic [PINS_MAX-1:0] low_slice(input logic [BYTE_W-1:0] b, input tw_e w);
        case (w)
            TW_2:    return {2'b00, b[1:0]};
            TW_4:    return b[3:0];
            default: return {3'b000, b[0]};
        endcase
    endfunction
endpackage

// File: rtl/trace_cfg.sv
// Holds the protocol and port-size fields and decodes them.
// Assumes the write strobe is already qualified by register decoding.
module trace_cfg
    import trace_port_pkg::*;
#(
    parameter logic [1:0] PROTO_RST = 2'b01,
    parameter logic [3:0] SIZE_RST  = 4'h1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [1:0] proto_in,
    input  logic [3:0] size_in,
    output logic [1:0] proto_q,
    output logic [3:0] size_q,
    output logic       sync_mode,
    output tw_e        width
);
    // Field storage with reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proto_q <= PROTO_RST;
            size_q  <= SIZE_RST;
        end else if (we) begin
            proto_q <= proto_in;
            size_q  <= size_in;
        end
    end

    // Decode of the stored fields.
    always_comb begin
        sync_mode = (proto_q == 2'b00);
        width     = size_decode(size_q);
    end

    // Fields sit at their reset values on the edge that releases reset.
    assert_rst_vals_R1: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (proto_q == PROTO_RST && size_q == SIZE_RST));
    // A write lands on the next edge.
    assert_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (proto_q == $past(proto_in) && size_q == $past(size_in)));
endmodule

// File: rtl/trace_clk_handover.sv
// Delays the trace I/O enable by HANDOVER clocks to produce the
// trace clock run enable. Assumes the enable input is synchronous to clk.
module trace_clk_handover #(
    parameter int HANDOVER = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic io_en,
    output logic run
);
    logic [HANDOVER-1:0] stg_q;

    generate
        if (HANDOVER == 1) begin : g_one
            // Single stage delay.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= io_en;
            end
        end else begin : g_chain
            // Shift chain of enable samples.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= {stg_q[HANDOVER-2:0], io_en};
            end
        end
    endgenerate

    assign run = stg_q[HANDOVER-1];

    generate
        if (HANDOVER == 2) begin : g_chk
            // Clock starts only two edges after the enable was seen high.
            assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(run) |-> $past(io_en, 2));
            // Clock stops only two edges after the enable was seen low.
            assert_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(run) |-> !$past(io_en, 2));
        end
    endgenerate
endmodule

// File: rtl/trace_slicer.sv
// Takes formatter bytes and drives them onto the data pins as slices of
// the width latched at each byte start. Assumes run and sync come from
// registers, so they are stable between edges.
module trace_slicer
    import trace_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                sync_mode,
    input  tw_e                 width,
    input  logic                in_valid,
    input  logic [BYTE_W-1:0]   in_data,
    output logic                in_ready,
    output logic [PINS_MAX-1:0] trace_d
);
    logic [BYTE_W-1:0] sh_q;
    logic [2:0]        rem_q;
    tw_e               w_q;
    logic              go;

    // Data moves only with the clock running in synchronous mode.
    always_comb begin
        go       = run && sync_mode;
        in_ready = go && (rem_q == 3'd0);
    end

    // Byte load, slice shift and idle handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            rem_q   <= '0;
            w_q     <= TW_1;
            trace_d <= '0;
        end else if (!go) begin
            rem_q   <= '0;
            trace_d <= '0;
        end else if (rem_q != 3'd0) begin
            trace_d <= low_slice(sh_q, w_q);
            sh_q    <= sh_q >> width_bits(w_q);
            rem_q   <= rem_q - 3'd1;
        end else if (in_valid) begin
            trace_d <= low_slice(in_data, width);
            sh_q    <= in_data >> width_bits(width);
            rem_q   <= last_slice(width);
            w_q     <= width;
        end else begin
            trace_d <= '0;
        end
    end

    // Non-synchronous protocol forces the pins low on the next edge.
    assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_mode |=> (trace_d == '0));
    // A stopped clock forces the pins low on the next edge.
    assert_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (trace_d == '0));
    // Pins outside the latched width stay low.
    assert_unused1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q == TW_1) |-> (trace_d[3:1] == 3'b000));
    assert_unused2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q == TW_2) |-> (trace_d[3:2] == 2'b00));
    // Width cannot change in the middle of a byte.
    assert_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rem_q) != 3'd0) |-> $stable(w_q));
    // Slice count never exceeds the byte length at the latched width.
    assert_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rem_q <= last_slice(w_q));
endmodule

// File: rtl/trace_port_sync.sv
// Top of the synchronous trace port: configuration fields, trace clock
// hand-over and byte slicer. Assumes all inputs are synchronous to clk.
module trace_port_sync
    import trace_port_pkg::*;
#(
    parameter logic [1:0] PROTO_RST = 2'b01,
    parameter logic [3:0] SIZE_RST  = 4'h1,
    parameter int         HANDOVER  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trace_io_en,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_proto_in,
    input  logic [3:0]          cfg_size_in,
    output logic [1:0]          cfg_proto,
    output logic [3:0]          cfg_size,
    input  logic                in_valid,
    input  logic [BYTE_W-1:0]   in_data,
    output logic                in_ready,
    output logic                tclk_run,
    output logic [PINS_MAX-1:0] trace_d
);
    logic sync_mode;
    tw_e  width;

    trace_cfg #(.PROTO_RST(PROTO_RST), .SIZE_RST(SIZE_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we),
        .proto_in(cfg_proto_in), .size_in(cfg_size_in),
        .proto_q(cfg_proto), .size_q(cfg_size),
        .sync_mode(sync_mode), .width(width)
    );

    trace_clk_handover #(.HANDOVER(HANDOVER)) u_hand (
        .clk(clk), .rst_n(rst_n), .io_en(trace_io_en), .run(tclk_run)
    );

    trace_slicer u_slice (
        .clk(clk), .rst_n(rst_n), .run(tclk_run), .sync_mode(sync_mode),
        .width(width), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .trace_d(trace_d)
    );

    // Handshake only completes while the trace clock runs.
    assert_ready_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> tclk_run);
endmodule

// File: tb/trace_port_sync_bench.sv
module trace_port_sync_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trace_io_en = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_proto_in = 2'b00;
    logic [3:0] cfg_size_in = 4'h1;
    logic [1:0] cfg_proto;
    logic [3:0] cfg_size;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       tclk_run;
    logic [3:0] trace_d;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    trace_port_sync u_trace_port_sync (
        .clk(clk), .rst_n(rst_n), .trace_io_en(trace_io_en),
        .cfg_we(cfg_we), .cfg_proto_in(cfg_proto_in), .cfg_size_in(cfg_size_in),
        .cfg_proto(cfg_proto), .cfg_size(cfg_size),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .tclk_run(tclk_run), .trace_d(trace_d)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_slice(input logic [7:0] b, input int p, input int k);
        logic [7:0] s;
        s = b >> (k * p);
        return s[3:0] & 4'((1 << p) - 1);
    endfunction

    task automatic write_cfg(input logic [1:0] pr, input logic [3:0] sz);
        @(negedge clk);
        cfg_we = 1'b1; cfg_proto_in = pr; cfg_size_in = sz;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Sends one byte from idle and checks every slice and ready.
    task automatic send_byte(input logic [7:0] b, input int p, input string req);
        int n;
        n = 8 / p;
        @(negedge clk);
        check(in_ready == 1'b1, "R8 ready at idle", in_ready, 1);
        in_valid = 1'b1; in_data = b;
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            check(trace_d == exp_slice(b, p, i), req, trace_d, exp_slice(b, p, i));
            check(in_ready == (i == n - 1), "R8 ready timing", in_ready, (i == n - 1));
        end
        @(negedge clk);
        check(trace_d == 4'h0, "R5 idle pins", trace_d, 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(cfg_proto == 2'b01, "R1 proto reset", cfg_proto, 1);
        check(cfg_size == 4'h1, "R1 size reset", cfg_size, 1);
        check(tclk_run == 1'b0, "R2 clock off at reset", tclk_run, 0);
        check(trace_d == 4'h0 && in_ready == 1'b0, "R9 quiet at reset", trace_d, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg_proto == 2'b01 && cfg_size == 4'h1, "R1 after release", cfg_proto, 1);
    endtask

    task automatic t_handover;
        trace_io_en = 1'b1;
        @(negedge clk);
        check(tclk_run == 1'b0, "R2 one edge after enable", tclk_run, 0);
        @(negedge clk);
        check(tclk_run == 1'b1, "R2 two edges after enable", tclk_run, 1);
    endtask

    task automatic t_widths;
        write_cfg(2'b00, 4'h1);
        check(cfg_proto == 2'b00 && cfg_size == 4'h1, "R1 write lands", cfg_size, 1);
        send_byte(8'hA5, 1, "R4 one pin slice");
        write_cfg(2'b00, 4'h2);
        send_byte(8'h3C, 2, "R4 two pin slice");
        write_cfg(2'b00, 4'h8);
        send_byte(8'h96, 4, "R4 four pin slice");
        write_cfg(2'b00, 4'h4);
        send_byte(8'h6B, 1, "R3 code 4 is one pin");
        write_cfg(2'b00, 4'hF);
        send_byte(8'hD2, 1, "R3 code F is one pin");
    endtask

    task automatic t_back_to_back;
        write_cfg(2'b00, 4'h8);
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'h1E;
        @(negedge clk);
        check(trace_d == 4'hE, "R8 first byte slice0", trace_d, 4'hE);
        check(in_ready == 1'b0, "R8 busy mid byte", in_ready, 0);
        in_data = 8'hC7;
        @(negedge clk);
        check(trace_d == 4'h1, "R8 first byte slice1", trace_d, 4'h1);
        check(in_ready == 1'b1, "R8 ready on last slice", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0;
        check(trace_d == 4'h7, "R8 second byte no gap", trace_d, 4'h7);
        @(negedge clk);
        check(trace_d == 4'hC, "R8 second byte slice1", trace_d, 4'hC);
        @(negedge clk);
    endtask

    task automatic t_boundary;
        logic [7:0] b;
        b = 8'hC3;
        write_cfg(2'b00, 4'h1);
        @(negedge clk);
        in_valid = 1'b1; in_data = b;
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i > 0) @(negedge clk);
            cfg_we = 1'b0;
            check(trace_d == exp_slice(b, 1, i), "R7 width held mid byte", trace_d, exp_slice(b, 1, i));
            if (i == 2) begin
                cfg_we = 1'b1; cfg_proto_in = 2'b00; cfg_size_in = 4'h8;
            end
        end
        check(cfg_size == 4'h8, "R7 new code stored", cfg_size, 8);
        send_byte(8'h5A, 4, "R7 new width on next byte");
    endtask

    task automatic t_protocol;
        write_cfg(2'b01, 4'h8);
        in_valid = 1'b1; in_data = 8'h77;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(in_ready == 1'b0 && trace_d == 4'h0, "R6 serial mode quiet", {in_ready, trace_d}, 0);
        end
        cfg_we = 1'b1; cfg_proto_in = 2'b00; cfg_size_in = 4'h8;
        @(negedge clk);
        cfg_we = 1'b0;
        check(in_ready == 1'b1, "R6 ready after sync", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0;
        check(trace_d == 4'h7, "R6 held byte sent", trace_d, 7);
        @(negedge clk);
        check(trace_d == 4'h7, "R6 held byte slice1", trace_d, 7);
        @(negedge clk);
    endtask

    task automatic t_clock_stop;
        trace_io_en = 1'b0;
        @(negedge clk);
        check(tclk_run == 1'b1, "R2 one edge after disable", tclk_run, 1);
        @(negedge clk);
        check(tclk_run == 1'b0, "R2 two edges after disable", tclk_run, 0);
        in_valid = 1'b1; in_data = 8'hFF;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(in_ready == 1'b0 && trace_d == 4'h0, "R9 no data while stopped", {in_ready, trace_d}, 0);
        end
        in_valid = 1'b0;
    endtask

    initial begin
        t_reset();
        t_handover();
        t_widths();
        t_back_to_back();
        t_boundary();
        t_protocol();
        t_clock_stop();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule